// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the processor-side register file of a floppy disk controller. A host reaches four register addresses through a chip select, a direction strobe and a 2-bit address. The block holds the track, sector and data registers and a command register. It keeps the busy state of the current command and raises a data-request flag and an interrupt request. Behind it sits a disk-side engine. The engine receives each accepted command as a one-cycle start pulse with its code. It pushes or pulls bytes through the data register and reports the end of a command on a completion input.

The data bus is split into input, output and output-enable vectors. The pad tristate combines them outside the block. Every clock in which chip select is low counts as one access. Read side effects take place at the edge that ends that cycle. Address 00 is asymmetric: a read returns status and a write loads a command. The meaning of data request depends on the direction of the transfer. For a read it means the data register holds a byte for the host. For a write it means the data register is empty and needs a byte.

Top module: `fdc_host_regs`

## Requirements
- R1: While `cs_n` is high, `d_oe` is low and no register, flag or command changes because of `rw`, `addr` or `d_in`.
- R2: With `cs_n` low, `rw` high drives the selected register onto `d_out` with `d_oe` high. `rw` low stores `d_in` at the clock edge. Address 01 is track, 10 is sector and 11 is data, in both directions.
- R3: A write to address 00 while not busy stores the command. It sets busy and gives `cmd_start` high for exactly the next cycle, with `cmd_code` holding the command.
- R4: A read of address 00 returns status: bit 0 is busy, bit 1 is data request, and bits 7..2 are zero.
- R5: `cmd_done` while busy clears busy and data request and sets `intrq` at the same edge. `cmd_done` while idle has no effect.
- R6: A status read clears `intrq`. If completion arrives in the same cycle, `intrq` ends up set.
- R7: A command with bits 7..5 = 100 is a read transfer. While it is busy, `eng_rd_valid` loads `eng_rd_byte` into the data register and sets `drq`. A host read of address 11 clears `drq`.
- R8: A command with bits 7..5 = 101 is a write transfer. It sets `drq` when accepted, and a host write of address 11 clears it. `eng_wr_take` with `drq` low sets it again, and `eng_wr_byte` always shows the data register.
- R9: A command write while busy, whose bits 7..4 are not 1101, is ignored. `cmd_code` keeps its value and no `cmd_start` is given.
- R10: A command write with bits 7..4 = 1101 always clears busy and `drq`, sets `intrq` and gives no `cmd_start`.
- R11: `mr_n` low at a clock edge clears every register, busy, `drq`, `intrq` and `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Master reset, active low, synchronous |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Register address |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Output enable for the host data bus |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 8 | Last accepted command |
| cmd_done | input | 1 | Engine reports command completion |
| eng_rd_valid | input | 1 | Engine delivers a byte (read transfer) |
| eng_rd_byte | input | 8 | Byte from the engine |
| eng_wr_take | input | 1 | Engine takes the data byte (write transfer) |
| eng_wr_byte | output | 8 | Data register toward the engine |

## Verification
The bench drives a stray write with chip select high. A design that ignored the select would corrupt the track register on the next read-back. Completion is raised while idle, to catch a design that sets the interrupt without a running command. A non-terminating command is written while busy, to catch a design that overwrites the running command. The bench reads status in the same cycle as completion, where a design with the wrong priority loses the interrupt. It also drives the data-request flag in both directions, which exposes a design that inverts its meaning for writes. A reset in the middle of a command must leave nothing pending.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam int ST_BUSY = 0;
    localparam int ST_DRQ  = 1;
    localparam logic [3:0] FORCE_NIB = 4'hD;
    localparam logic [2:0] RD_GRP    = 3'b100;
    localparam logic [2:0] WR_GRP    = 3'b101;

    typedef enum logic [AW-1:0] {
        SEL_STATCMD = 2'd0,
        SEL_TRACK   = 2'd1,
        SEL_SECTOR  = 2'd2,
        SEL_DATA    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        reg_sel_e      sel;
        logic [DW-1:0] wdata;
    } host_acc_t;

    function automatic logic is_force(input logic [DW-1:0] c);
        return c[DW-1 -: 4] == FORCE_NIB;
    endfunction

    function automatic xfer_e xfer_of(input logic [DW-1:0] c);
        if (c[DW-1 -: 3] == RD_GRP) return XF_READ;
        if (c[DW-1 -: 3] == WR_GRP) return XF_WRITE;
        return XF_NONE;
    endfunction
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
    import fdc_host_pkg::*;
(
    input  logic               cs_n,
    input  logic               rw,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      d_in,
    output host_acc_t          acc,
    output logic               oe
);
    always_comb begin
        acc.rd    = !cs_n && rw;
        acc.wr    = !cs_n && !rw;
        acc.sel   = reg_sel_e'(addr);
        acc.wdata = d_in;
        oe        = acc.rd;
    end
endmodule

// File: rtl/fdc_cmd_ctrl.sv
module fdc_cmd_ctrl
    import fdc_host_pkg::*;
(
    input  logic      clk,
    input  logic      mr_n,
    input  host_acc_t acc,
    input  logic      cmd_done,
    input  logic      eng_rd_valid,
    input  logic      eng_wr_take,
    output logic      busy,
    output logic      drq,
    output logic      intrq,
    output logic      cmd_load,
    output logic      eng_load,
    output logic      cmd_start
);
    xfer_e xfer_q, xfer_d;
    logic  busy_d, drq_d, irq_d;
    logic  cmd_wr, is_frc;

    assign cmd_wr   = acc.wr && acc.sel == SEL_STATCMD;
    assign is_frc   = is_force(acc.wdata);
    assign cmd_load = cmd_wr && !is_frc && !busy;
    assign eng_load = eng_rd_valid && busy && xfer_q == XF_READ;

    always_comb begin
        busy_d = busy;
        drq_d  = drq;
        irq_d  = intrq;
        xfer_d = xfer_q;
        if (acc.rd && acc.sel == SEL_STATCMD) irq_d = 1'b0;
        if (busy && acc.sel == SEL_DATA) begin
            if (acc.rd && xfer_q == XF_READ)  drq_d = 1'b0;
            if (acc.wr && xfer_q == XF_WRITE) drq_d = 1'b0;
        end
        if (eng_load) drq_d = 1'b1;
        if (eng_wr_take && busy && xfer_q == XF_WRITE && !drq) drq_d = 1'b1;
        if (cmd_wr && is_frc) begin
            busy_d = 1'b0;
            drq_d  = 1'b0;
            irq_d  = 1'b1;
        end else if (cmd_load) begin
            busy_d = 1'b1;
            xfer_d = xfer_of(acc.wdata);
            drq_d  = xfer_d == XF_WRITE;
        end
        if (cmd_done && busy) begin
            busy_d = 1'b0;
            drq_d  = 1'b0;
            irq_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            busy      <= 1'b0;
            drq       <= 1'b0;
            intrq     <= 1'b0;
            xfer_q    <= XF_NONE;
            cmd_start <= 1'b0;
        end else begin
            busy      <= busy_d;
            drq       <= drq_d;
            intrq     <= irq_d;
            xfer_q    <= xfer_d;
            cmd_start <= cmd_load;
        end
    end
endmodule

// File: rtl/fdc_reg_file.sv
module fdc_reg_file
    import fdc_host_pkg::*;
(
    input  logic          clk,
    input  logic          mr_n,
    input  host_acc_t     acc,
    input  logic          cmd_load,
    input  logic          eng_load,
    input  logic [DW-1:0] eng_byte,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] data_q
);
    logic [DW-1:0] trk_q, sec_q;

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            trk_q  <= '0;
            sec_q  <= '0;
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (acc.wr && acc.sel == SEL_TRACK)  trk_q <= acc.wdata;
            if (acc.wr && acc.sel == SEL_SECTOR) sec_q <= acc.wdata;
            if (cmd_load) cmd_q <= acc.wdata;
            if (eng_load) data_q <= eng_byte;
            else if (acc.wr && acc.sel == SEL_DATA) data_q <= acc.wdata;
        end
    end

    always_comb begin
        unique case (acc.sel)
            SEL_STATCMD: rdata = status;
            SEL_TRACK:   rdata = trk_q;
            SEL_SECTOR:  rdata = sec_q;
            default:     rdata = data_q;
        endcase
    end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_host_pkg::*;
(
    input  logic          clk,
    input  logic          mr_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [1:0]    addr,
    input  logic [7:0]    d_in,
    output logic [7:0]    d_out,
    output logic          d_oe,
    output logic          drq,
    output logic          intrq,
    output logic          cmd_start,
    output logic [7:0]    cmd_code,
    input  logic          cmd_done,
    input  logic          eng_rd_valid,
    input  logic [7:0]    eng_rd_byte,
    input  logic          eng_wr_take,
    output logic [7:0]    eng_wr_byte
);
    host_acc_t     acc;
    logic          busy, cmd_load, eng_load;
    logic [DW-1:0] status;

    fdc_bus_decode u_dec (
        .cs_n(cs_n), .rw(rw), .addr(addr), .d_in(d_in), .acc(acc), .oe(d_oe)
    );

    fdc_cmd_ctrl u_ctrl (
        .clk(clk), .mr_n(mr_n), .acc(acc), .cmd_done(cmd_done),
        .eng_rd_valid(eng_rd_valid), .eng_wr_take(eng_wr_take),
        .busy(busy), .drq(drq), .intrq(intrq), .cmd_load(cmd_load),
        .eng_load(eng_load), .cmd_start(cmd_start)
    );

    always_comb begin
        status          = '0;
        status[ST_BUSY] = busy;
        status[ST_DRQ]  = drq;
    end

    fdc_reg_file u_regs (
        .clk(clk), .mr_n(mr_n), .acc(acc), .cmd_load(cmd_load),
        .eng_load(eng_load), .eng_byte(eng_rd_byte), .status(status),
        .rdata(d_out), .cmd_q(cmd_code), .data_q(eng_wr_byte)
    );
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk (
    input logic       clk,
    input logic       mr_n,
    input logic       cs_n,
    input logic       rw,
    input logic [1:0] addr,
    input logic [7:0] d_in,
    input logic       cmd_done,
    input logic       cmd_start,
    input logic [7:0] cmd_code,
    input logic       intrq,
    input logic       drq,
    input logic       busy
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!mr_n)
        cmd_start |=> !cmd_start); // R3
    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!mr_n)
        cmd_start |-> busy); // R3
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!mr_n)
        (cmd_done && busy) |=> (intrq && !busy && !drq)); // R5
    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!mr_n)
        (!cs_n && rw && addr == 2'd0 && !(cmd_done && busy)) |=> !intrq); // R6
    AST_DRQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!mr_n)
        drq |-> busy); // R8
    AST_BUSY_CMD_KEPT: assert property (@(posedge clk) disable iff (!mr_n)
        (busy && !cs_n && !rw && addr == 2'd0 && d_in[7:4] != 4'hD)
        |=> ($stable(cmd_code) && !cmd_start)); // R9
    AST_FORCE_ENDS: assert property (@(posedge clk) disable iff (!mr_n)
        (!cs_n && !rw && addr == 2'd0 && d_in[7:4] == 4'hD)
        |=> (!busy && intrq && !cmd_start)); // R10
endmodule

bind fdc_host_regs fdc_host_regs_chk u_chk (.*);

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
    logic       clk = 1'b0;
    logic       mr_n, cs_n, rw, cmd_done, eng_rd_valid, eng_wr_take;
    logic [1:0] addr;
    logic [7:0] d_in, eng_rd_byte;
    logic [7:0] d_out, cmd_code, eng_wr_byte;
    logic       d_oe, drq, intrq, cmd_start;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done_flag = 0;

    // behavioural model state
    int m_trk, m_sec, m_dat, m_cmd, m_dir; // dir: 0 none, 1 read, 2 write
    bit m_busy, m_drq, m_irq, m_start;

    always #2 clk = ~clk; // 250 MHz

    fdc_host_regs i_fdc_host_regs (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_trk = 0; m_sec = 0; m_dat = 0; m_cmd = 0; m_dir = 0;
        m_busy = 0; m_drq = 0; m_irq = 0; m_start = 0;
    endtask

    // one bus cycle: drive at negedge, compare, step the model at posedge
    task automatic cyc(input string req, input bit rst, input bit cs, input bit r,
                       input int a, input int d, input bit done,
                       input bit rdv, input int rdb, input bit take);
        bit ob, od, oi, rd, wr;
        int exp_out;
        @(negedge clk);
        mr_n = !rst; cs_n = cs; rw = r; addr = a[1:0]; d_in = d[7:0];
        cmd_done = done; eng_rd_valid = rdv; eng_rd_byte = rdb[7:0]; eng_wr_take = take;
        #1;
        rd = !cs && r; wr = !cs && !r;
        chk(req, "d_oe", d_oe, rd);
        if (rd) begin
            case (a)
                0: exp_out = {m_drq, m_busy};
                1: exp_out = m_trk;
                2: exp_out = m_sec;
                default: exp_out = m_dat;
            endcase
            chk(req, "d_out", d_out, exp_out);
        end
        chk(req, "drq", drq, m_drq);
        chk(req, "intrq", intrq, m_irq);
        chk(req, "cmd_start", cmd_start, m_start);
        chk(req, "cmd_code", cmd_code, m_cmd);
        chk(req, "eng_wr_byte", eng_wr_byte, m_dat);
        // next state
        ob = m_busy; od = m_drq; oi = m_irq;
        if (rst) begin
            model_reset();
        end else begin
            m_start = 0;
            if (rd && a == 0) m_irq = 0;
            if (wr && a == 1) m_trk = d;
            if (wr && a == 2) m_sec = d;
            if (wr && a == 3) begin
                m_dat = d;
                if (ob && m_dir == 2) m_drq = 0;
            end
            if (rd && a == 3 && ob && m_dir == 1) m_drq = 0;
            if (rdv && ob && m_dir == 1) begin m_dat = rdb; m_drq = 1; end
            if (take && ob && m_dir == 2 && !od) m_drq = 1;
            if (wr && a == 0) begin
                if ((d >> 4) == 'hD) begin
                    m_busy = 0; m_drq = 0; m_irq = 1;
                end else if (!ob) begin
                    m_cmd = d; m_busy = 1; m_start = 1;
                    m_dir = ((d >> 5) == 4) ? 1 : ((d >> 5) == 5) ? 2 : 0;
                    m_drq = (m_dir == 2);
                end
            end
            if (done && ob) begin m_busy = 0; m_drq = 0; m_irq = 1; end
        end
        if (oi) ; // previous irq kept for clarity of ordering only
    endtask

    task automatic idle(input string req);
        cyc(req, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic hwr(input string req, input int a, input int d);
        cyc(req, 0, 0, 0, a, d, 0, 0, 0, 0);
    endtask
    task automatic hrd(input string req, input int a);
        cyc(req, 0, 0, 1, a, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        model_reset();
        mr_n = 0; cs_n = 1; rw = 1; addr = 0; d_in = 0;
        cmd_done = 0; eng_rd_valid = 0; eng_rd_byte = 0; eng_wr_take = 0;
        @(posedge clk);
        cyc("R11", 1, 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R11", 1, 1, 1, 0, 0, 0, 0, 0, 0);
        hrd("R4", 0);
        // R2 register map
        hwr("R2", 1, 'h22); hwr("R2", 2, 'h05); hwr("R2", 3, 'h3C);
        hrd("R2", 1); hrd("R2", 2); hrd("R2", 3);
        // R1 stray write with select high
        cyc("R1", 0, 1, 0, 1, 'hFF, 0, 0, 0, 0);
        cyc("R1", 0, 1, 0, 0, 'h10, 0, 0, 0, 0);
        hrd("R1", 1); hrd("R1", 0);
        // R5 completion while idle ignored
        cyc("R5", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        idle("R5");
        // R3 plain command, R9 ignored while busy
        hwr("R3", 0, 'h10); idle("R3"); hrd("R4", 0);
        hwr("R9", 0, 'h20); idle("R9"); idle("R9");
        cyc("R5", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        idle("R5"); hrd("R6", 0); idle("R6");
        // R7 read transfer
        hwr("R7", 0, 'h80); idle("R7");
        cyc("R7", 0, 1, 1, 0, 0, 0, 1, 'hA5, 0);
        hrd("R7", 0); hrd("R7", 3); idle("R7");
        cyc("R7", 0, 1, 1, 0, 0, 0, 1, 'h96, 0);
        hrd("R7", 3);
        cyc("R5", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        hrd("R6", 0);
        // R8 write transfer, R10 force
        hwr("R8", 0, 'hA0); idle("R8"); hrd("R8", 0);
        hwr("R8", 3, 'h5A); idle("R8");
        cyc("R8", 0, 1, 1, 0, 0, 0, 0, 0, 1); idle("R8");
        cyc("R8", 0, 1, 1, 0, 0, 0, 0, 0, 1); idle("R8");
        cyc("R7", 0, 1, 1, 0, 0, 0, 1, 'h11, 0); idle("R7");
        hwr("R10", 0, 'hD0); idle("R10"); hrd("R10", 0); idle("R10");
        hwr("R10", 0, 'hD4); idle("R10"); hrd("R6", 0);
        // R6 status read racing completion
        hwr("R3", 0, 'h30); idle("R3");
        cyc("R6", 0, 0, 1, 0, 0, 1, 0, 0, 0);
        idle("R6"); hrd("R6", 0); idle("R6");
        // R11 reset mid command
        hwr("R11", 0, 'hA0); idle("R11");
        cyc("R11", 1, 1, 1, 0, 0, 0, 0, 0, 0);
        idle("R11"); hrd("R11", 1); hrd("R11", 0);
        idle("R11");
        finish_run();
    end
endmodule